// File: doc/BRIEF.md
# Collision-Avoidance Override Arbiter

This block decides who drives a small ground vehicle: the operator or the safety logic. Each cycle it chooses between the operator's speed and steering commands and a pair of action values that a host processor has written. The choice depends on a threat indication from the ranging logic and on the authority mode that the host has selected. It also drives a buzzer enable and raises an interrupt towards the host whenever a new threat appears. The host reads the threat class through a small register bus, and that read acknowledges the interrupt.

There are three authority modes. In manual mode the block never overrides the operator. In warning mode a threat first sounds the buzzer. The operator then has a programmable number of 20 ms frames to react by easing off the throttle or by steering away from the threatened side; without such a reaction the block takes over. In immediate mode a threat hands control to the host actions at once. After a take-over, control goes back to the operator only once the threat has been absent for a fixed number of consecutive frames.

Top module: `collision_override_arb`

## Requirements
- R1: After reset the outputs pass the operator commands, the buzzer and the interrupt are low, the action registers read 128 (neutral), and the mode register reads 0x2A (grace 10 frames in bits [7:2], warning mode 2 in bits [1:0]).
- R2: In manual mode (mode field 0 or 1) a threat never changes speedOut or steerOut away from the operator commands, and the buzzer stays off.
- R3: In warning mode (mode field 2), a threat that arrives while the operator drives turns the buzzer on from the next cycle, and the operator commands still pass through.
- R4: In warning mode, when the operator makes no correction within the grace period (counted in frames), the outputs switch to the speed-action and turn-action registers and the buzzer turns off.
- R5: During a warning, a correction ends the warning: either the speed magnitude |speed-128| falls below its value when the warning began, or the steering moves away from the threat side (above its starting value when threatOnLeft=1, below it when threatOnLeft=0). After a correction the buzzer is off and the operator keeps control even after the grace period. A steering move towards the threat side is not a correction.
- R6: In immediate mode (mode field 3), a threat appearing while the operator drives makes the outputs equal the action registers after the next clock edge.
- R7: Control returns to the operator only after threatValid has been low through 3 consecutive frame boundaries. Any cycle with threatValid high restarts that count.
- R8: A threat rising, or a change of threat class while the threat stays valid, raises irqReq and loads the class code (1 head-on, 2 blind-spot, 3 reversing) into register 0. A read of register 0 returns that code and clears irqReq.
- R9: A pending class is replaced only by a new class of higher priority (head-on over blind-spot over reversing). Lower-priority events leave it unchanged.
- R10: Register map (3-bit address, 8-bit data): 0 class, 1 current speed, 2 distance, 3 speed action, 4 turn action, 5 mode. Addresses 6 and 7 read 0. Read data appears one cycle after regRdEn.
- R11: A write to an action register while the block holds control changes the driven command from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| userSpeed | input | 8 | Operator speed command, 128 neutral |
| userSteer | input | 8 | Operator steering command, 128 straight, larger is right |
| threatValid | input | 1 | Imminent threat reported by ranging logic |
| threatKind | input | 2 | Threat class: 1 head-on, 2 blind-spot, 3 reversing |
| threatOnLeft | input | 1 | 1 when the threat lies on the left side |
| curSpeed | input | 8 | Measured speed, readable at address 1 |
| distance | input | 8 | Measured distance, readable at address 2 |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Registered read data |
| speedOut | output | 8 | Final speed command |
| steerOut | output | 8 | Final steering command |
| buzzerOn | output | 1 | Audible warning enable |
| irqReq | output | 1 | Interrupt request to host |

## Verification
The bench builds the block with a 10-cycle frame instead of the real 20 ms frame. With that setting the grace window, the three-frame release and the restart of the release count all happen within a few dozen cycles, so both sides of each frame boundary can be checked. The bench writes a grace of 3 frames through the mode register so that the take-over point falls between two checks whose cycle windows are known. The default grace of 10 frames and the release count of 3 are left at their defaults.

// File: rtl/coa_pkg.sv
package coa_pkg;

  typedef enum logic [1:0] {
    ST_USER  = 2'd0,
    ST_WARN  = 2'd1,
    ST_HEED  = 2'd2,
    ST_TAKEN = 2'd3
  } authState_t;

  typedef struct packed {
    logic selAction;
    logic buzz;
    logic captureRef;
  } ctlStrobe_t;

  localparam logic [1:0] THR_NONE  = 2'd0;
  localparam logic [1:0] THR_HEAD  = 2'd1;
  localparam logic [1:0] THR_BLIND = 2'd2;
  localparam logic [1:0] THR_REV   = 2'd3;

  localparam logic [1:0] MODE_WARN = 2'd2;
  localparam logic [1:0] MODE_TAKE = 2'd3;

  localparam logic [2:0] ADR_INT   = 3'd0;
  localparam logic [2:0] ADR_SPEED = 3'd1;
  localparam logic [2:0] ADR_DIST  = 3'd2;
  localparam logic [2:0] ADR_SACT  = 3'd3;
  localparam logic [2:0] ADR_TACT  = 3'd4;
  localparam logic [2:0] ADR_MODE  = 3'd5;

endpackage

// File: rtl/coa_datapath.sv
module coa_datapath
  import coa_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int FRAME_CYCLES = 5_000_000,
  parameter int GRACE_RESET  = 10,
  localparam int GRACE_W     = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] userSpeed,
  input  logic [DATA_W-1:0] userSteer,
  input  logic              threatValid,
  input  logic [1:0]        threatKind,
  input  logic              threatOnLeft,
  input  logic [DATA_W-1:0] curSpeed,
  input  logic [DATA_W-1:0] distance,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  input  ctlStrobe_t        ctl,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] speedOut,
  output logic [DATA_W-1:0] steerOut,
  output logic              buzzerOn,
  output logic              irqReq,
  output logic              frameTick,
  output logic              corrective,
  output logic [1:0]        modeSel,
  output logic [GRACE_W-1:0] graceLim
);

  localparam int FRAME_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [DATA_W-1:0] NEUTRAL = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] MODE_RESET = {GRACE_W'(GRACE_RESET), MODE_WARN};

  logic [FRAME_W-1:0] frameCnt;
  logic [DATA_W-1:0]  speedAct, turnAct, modeReg, refSpeed, refSteer, rdMux;
  logic [1:0]         intType, kindQ;
  logic               validQ, detectEvt, promote, rdInt;

  // frame timer
  assign frameTick = (frameCnt == FRAME_W'(FRAME_CYCLES - 1));
  always_ff @(posedge clk) begin
    if (!rstN || frameTick) frameCnt <= '0;
    else                    frameCnt <= frameCnt + 1'b1;
  end

  // host-writable registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedAct <= NEUTRAL;
      turnAct  <= NEUTRAL;
      modeReg  <= MODE_RESET;
    end else if (regWrEn) begin
      case (regAddr)
        ADR_SACT: speedAct <= regWrData;
        ADR_TACT: turnAct  <= regWrData;
        ADR_MODE: modeReg  <= regWrData;
        default:  ;
      endcase
    end
  end
  assign modeSel  = modeReg[1:0];
  assign graceLim = modeReg[DATA_W-1:2];

  // threat class capture with priority (lower nonzero code wins)
  assign detectEvt = threatValid && (threatKind != THR_NONE) &&
                     (!validQ || (threatKind != kindQ));
  assign promote   = detectEvt && ((intType == THR_NONE) || (threatKind < intType));
  assign rdInt     = regRdEn && (regAddr == ADR_INT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      kindQ   <= THR_NONE;
      intType <= THR_NONE;
    end else begin
      validQ <= threatValid;
      kindQ  <= threatKind;
      if (rdInt)        intType <= detectEvt ? threatKind : THR_NONE;
      else if (promote) intType <= threatKind;
    end
  end
  assign irqReq = (intType != THR_NONE);

  // registered read port
  always_comb begin
    case (regAddr)
      ADR_INT:   rdMux = {{(DATA_W-2){1'b0}}, intType};
      ADR_SPEED: rdMux = curSpeed;
      ADR_DIST:  rdMux = distance;
      ADR_SACT:  rdMux = speedAct;
      ADR_TACT:  rdMux = turnAct;
      ADR_MODE:  rdMux = modeReg;
      default:   rdMux = '0;
    endcase
  end
  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

  // operator reaction detection against the commands seen at warning start
  function automatic logic [DATA_W-1:0] magOf(input logic [DATA_W-1:0] v);
    return (v >= NEUTRAL) ? (v - NEUTRAL) : (NEUTRAL - v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refSpeed <= NEUTRAL;
      refSteer <= NEUTRAL;
    end else if (ctl.captureRef) begin
      refSpeed <= userSpeed;
      refSteer <= userSteer;
    end
  end
  assign corrective = (magOf(userSpeed) < magOf(refSpeed)) ||
                      (threatOnLeft ? (userSteer > refSteer) : (userSteer < refSteer));

  // output selection
  assign speedOut = ctl.selAction ? speedAct : userSpeed;
  assign steerOut = ctl.selAction ? turnAct  : userSteer;
  assign buzzerOn = ctl.buzz;

  // R3
  warn_keeps_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.buzz |-> (speedOut == userSpeed && steerOut == userSteer));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdInt && !detectEvt) |=> !irqReq);

  // R9
  head_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intType == THR_HEAD && !rdInt) |=> (intType == THR_HEAD));

endmodule

// File: rtl/coa_control.sv
module coa_control
  import coa_pkg::*;
#(
  parameter int GRACE_W        = 6,
  parameter int RELEASE_FRAMES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               threatValid,
  input  logic               frameTick,
  input  logic               corrective,
  input  logic [1:0]         modeSel,
  input  logic [GRACE_W-1:0] graceLim,
  output ctlStrobe_t         ctl
);

  localparam int CLR_W = $clog2(RELEASE_FRAMES + 1);

  authState_t         state, stateNext;
  logic [GRACE_W-1:0] graceCnt, graceNext;
  logic [CLR_W-1:0]   clrCnt, clrNext;
  logic               manual, releaseNow, graceDone;

  assign manual     = (modeSel < MODE_WARN);
  assign releaseNow = !threatValid && frameTick &&
                      (clrCnt == CLR_W'(RELEASE_FRAMES - 1));
  assign graceDone  = (graceCnt >= graceLim);

  always_comb begin
    stateNext = state;
    graceNext = graceCnt;
    if (threatValid || releaseNow) clrNext = '0;
    else if (frameTick)            clrNext = clrCnt + 1'b1;
    else                           clrNext = clrCnt;

    case (state)
      ST_USER: begin
        graceNext = '0;
        if (threatValid && modeSel == MODE_TAKE)      stateNext = ST_TAKEN;
        else if (threatValid && modeSel == MODE_WARN) stateNext = ST_WARN;
      end
      ST_WARN: begin
        if (frameTick && graceCnt != '1) graceNext = graceCnt + 1'b1;
        if (manual || releaseNow)         stateNext = ST_USER;
        else if (modeSel == MODE_TAKE)    stateNext = ST_TAKEN;
        else if (corrective)              stateNext = ST_HEED;
        else if (graceDone)               stateNext = ST_TAKEN;
      end
      ST_HEED: begin
        if (manual || releaseNow) stateNext = ST_USER;
      end
      default: begin
        if (manual || releaseNow) stateNext = ST_USER;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_USER;
      graceCnt <= '0;
      clrCnt   <= '0;
    end else begin
      state    <= stateNext;
      graceCnt <= graceNext;
      clrCnt   <= clrNext;
    end
  end

  assign ctl.selAction  = (state == ST_TAKEN);
  assign ctl.buzz       = (state == ST_WARN);
  assign ctl.captureRef = (state == ST_USER) && threatValid && (modeSel == MODE_WARN);

  // R2
  manual_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    manual |=> (state == ST_USER));

  // R6
  immediate_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_USER && threatValid && modeSel == MODE_TAKE) |=> (state == ST_TAKEN));

  // R7
  hold_while_threat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAKEN && threatValid && !manual) |=> (state == ST_TAKEN));

endmodule

// File: rtl/collision_override_arb.sv
module collision_override_arb
  import coa_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int FRAME_CYCLES   = 5_000_000,
  parameter int GRACE_RESET    = 10,
  parameter int RELEASE_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] userSpeed,
  input  logic [DATA_W-1:0] userSteer,
  input  logic              threatValid,
  input  logic [1:0]        threatKind,
  input  logic              threatOnLeft,
  input  logic [DATA_W-1:0] curSpeed,
  input  logic [DATA_W-1:0] distance,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] speedOut,
  output logic [DATA_W-1:0] steerOut,
  output logic              buzzerOn,
  output logic              irqReq
);

  localparam int GRACE_W = DATA_W - 2;

  ctlStrobe_t         ctl;
  logic               frameTick, corrective;
  logic [1:0]         modeSel;
  logic [GRACE_W-1:0] graceLim;

  coa_datapath #(
    .DATA_W(DATA_W), .FRAME_CYCLES(FRAME_CYCLES), .GRACE_RESET(GRACE_RESET)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .userSpeed(userSpeed), .userSteer(userSteer),
    .threatValid(threatValid), .threatKind(threatKind), .threatOnLeft(threatOnLeft),
    .curSpeed(curSpeed), .distance(distance), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .ctl(ctl), .regRdData(regRdData),
    .speedOut(speedOut), .steerOut(steerOut), .buzzerOn(buzzerOn), .irqReq(irqReq),
    .frameTick(frameTick), .corrective(corrective), .modeSel(modeSel), .graceLim(graceLim)
  );

  coa_control #(
    .GRACE_W(GRACE_W), .RELEASE_FRAMES(RELEASE_FRAMES)
  ) control_i (
    .clk(clk), .rstN(rstN), .threatValid(threatValid), .frameTick(frameTick),
    .corrective(corrective), .modeSel(modeSel), .graceLim(graceLim), .ctl(ctl)
  );

endmodule

// File: tb/collision_override_arb_tb_top.sv
`timescale 1ns/1ps
module collision_override_arb_tb_top;

  localparam int FRAME = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] userSpeed = 8'd128, userSteer = 8'd128, curSpeed = 8'd0, distance = 8'd0;
  logic       threatValid = 1'b0, threatOnLeft = 1'b1;
  logic [1:0] threatKind = 2'd0;
  logic [2:0] regAddr = 3'd0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData, speedOut, steerOut;
  logic       buzzerOn, irqReq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit    isRead;
    string req;
    int    a;
    int    b;
    int    bz;
    int    irq;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  collision_override_arb #(.FRAME_CYCLES(FRAME)) dut_i (
    .clk(clk), .rstN(rstN), .userSpeed(userSpeed), .userSteer(userSteer),
    .threatValid(threatValid), .threatKind(threatKind), .threatOnLeft(threatOnLeft),
    .curSpeed(curSpeed), .distance(distance), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .speedOut(speedOut), .steerOut(steerOut), .buzzerOn(buzzerOn), .irqReq(irqReq)
  );

  // monitor: compares 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.isRead) begin
          checks++;
          if (int'(regRdData) != it.a) begin
            fails++;
            $display("FAIL %s: rdData got %0d expected %0d", it.req, regRdData, it.a);
          end
        end else begin
          checks++;
          if (int'(speedOut) != it.a || int'(steerOut) != it.b || int'(buzzerOn) != it.bz ||
              (it.irq >= 0 && int'(irqReq) != it.irq)) begin
            fails++;
            $display("FAIL %s: spd/str/bz/irq got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     it.req, speedOut, steerOut, buzzerOn, irqReq, it.a, it.b, it.bz, it.irq);
          end
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expOut(string req, int spd, int str, int bz, int irq);
    expItem_t it;
    it = '{isRead: 1'b0, req: req, a: spd, b: str, bz: bz, irq: irq};
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic expRd(string req, logic [2:0] adr, int val);
    expItem_t it;
    it = '{isRead: 1'b1, req: req, a: val, b: 0, bz: 0, irq: -1};
    regAddr = adr;
    regRdEn = 1'b1;
    expQ.push_back(it);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic wrReg(logic [2:0] adr, logic [7:0] val);
    regAddr   = adr;
    regWrData = val;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    step(4);
    rstN = 1'b1;
    userSpeed = 8'd150;
    userSteer = 8'd110;

    // R1 reset state
    expOut("R1", 150, 110, 0, 0);
    expRd("R1", 3'd5, 8'h2A);
    expRd("R1", 3'd3, 128);
    expRd("R1", 3'd4, 128);

    // R10 register map
    curSpeed = 8'd77;
    distance = 8'd33;
    expRd("R10", 3'd1, 77);
    expRd("R10", 3'd2, 33);
    wrReg(3'd3, 8'd40);
    wrReg(3'd4, 8'd200);
    expRd("R10", 3'd3, 40);
    expRd("R10", 3'd4, 200);
    expRd("R10", 3'd6, 0);
    expRd("R10", 3'd7, 0);

    // R2 manual mode ignores threats
    wrReg(3'd5, (8'd10 << 2) | 8'd1);
    userSpeed = 8'd200;
    userSteer = 8'd128;
    threatKind = 2'd1;
    threatValid = 1'b1;
    expOut("R2", 200, 128, 0, 1);
    step(50);
    expOut("R2", 200, 128, 0, -1);
    // R8 read returns class and clears irq
    expRd("R8", 3'd0, 1);
    expOut("R8", 200, 128, 0, 0);
    threatValid = 1'b0;
    step(5);

    // R6 immediate take-over
    wrReg(3'd5, (8'd10 << 2) | 8'd3);
    threatKind = 2'd3;
    threatValid = 1'b1;
    expOut("R6", 40, 200, 0, 1);
    // R11 action write applies while holding control
    regAddr = 3'd3; regWrData = 8'd60; regWrEn = 1'b1;
    expOut("R11", 60, 200, 0, -1);
    regWrEn = 1'b0;
    // R9 priority replacement
    threatKind = 2'd2;
    step(2);
    threatKind = 2'd3;
    step(2);
    expRd("R9", 3'd0, 2);
    threatKind = 2'd1;
    step(2);
    threatKind = 2'd2;
    step(2);
    expRd("R9", 3'd0, 1);

    // R7 release after three clear frames, restart on new threat
    threatValid = 1'b0;
    step(18);
    expOut("R7", 60, 200, 0, -1);
    step(12);
    expOut("R7", 200, 128, 0, -1);
    threatValid = 1'b1;
    step(3);
    threatValid = 1'b0;
    step(15);
    threatValid = 1'b1;
    step(1);
    threatValid = 1'b0;
    step(18);
    expOut("R7", 60, 200, 0, -1);
    step(12);
    expOut("R7", 200, 128, 0, -1);
    expRd("R8", 3'd0, 2);

    // R3 / R4 warning then take-over, grace 3 frames
    wrReg(3'd5, (8'd3 << 2) | 8'd2);
    threatKind = 2'd1;
    threatValid = 1'b1;
    expOut("R3", 200, 128, 1, 1);
    step(17);
    expOut("R3", 200, 128, 1, -1);
    step(14);
    expOut("R4", 60, 200, 0, -1);
    threatValid = 1'b0;
    step(35);
    expOut("R7", 200, 128, 0, -1);

    // R5 throttle easing cancels the warning
    threatValid = 1'b1;
    expOut("R5", 200, 128, 1, -1);
    userSpeed = 8'd170;
    expOut("R5", 170, 128, 0, -1);
    step(40);
    expOut("R5", 170, 128, 0, -1);
    threatValid = 1'b0;
    step(35);

    // R5 steering away from a left-side threat cancels the warning
    userSpeed = 8'd200;
    threatOnLeft = 1'b1;
    threatValid = 1'b1;
    expOut("R5", 200, 128, 1, -1);
    userSteer = 8'd160;
    expOut("R5", 200, 160, 0, -1);
    step(40);
    expOut("R5", 200, 160, 0, -1);
    threatValid = 1'b0;
    step(35);

    // R5 steering towards the threat is not a correction
    userSteer = 8'd128;
    threatValid = 1'b1;
    expOut("R5", 200, 128, 1, -1);
    userSteer = 8'd100;
    step(40);
    expOut("R5", 60, 200, 0, -1);
    threatValid = 1'b0;
    step(35);
    expOut("R7", 200, 100, 0, -1);

    step(3);
    summary();
  end

endmodule